// File: doc/BRIEF.md
# Gated Energy Integrator on a Mains-Derived Clock

This block accumulates a rough measure of consumed energy. It runs on a slow reference clock that is taken from half-wave-rectified 50 Hz mains, so one clock edge occurs every 20 ms. A 10-bit divider chain produces two slow taps, each a one-cycle enable pulse:

- **Count tick:** every 128 reference cycles, about 0.4 Hz.
- **Pacing pulse:** every 1024 reference cycles, about 0.05 Hz. This pulse leaves the block to step an external triangle-wave generator.

An external comparator compares the rectified load signal with that triangle and drives `cmp_i`. The block passes `cmp_i` through a two-flop synchroniser and uses the result as a count enable. On each count tick where the enable is high, a 10-bit accumulator advances by one. Because the comparator duty cycle tracks the load level, the count approximates the integral of the load.

The accumulator holds at all ones instead of wrapping. With the comparator held high, it reaches full scale after 1023 ticks, which is roughly 43 minutes. Its upper five bits drive a five-segment bar indicator. A synchronous clear restarts the divider and empties the accumulator together.

Top module: `energy_integrator`

## Requirements
- R1: While `rst_n` is low, `acc_o` and `bar_o` read 0, and `tick_o` and `pace_o` read 0.
- R2: `tick_o` is a one-cycle pulse that is high in the 128th cycle after a reset or clear edge. It then repeats every 128 cycles.
- R3: `pace_o` is a one-cycle pulse that is high in the 1024th cycle after a reset or clear edge. It then repeats every 1024 cycles, and it is always high together with `tick_o`.
- R4: `acc_o` increases by exactly one on a clock edge where `tick_o` is high and the synchronised enable is high. On every other non-clear edge it is unchanged.
- R5: `cmp_i` reaches the count enable through two flops. A level sampled on edge n acts as the enable on edge n+2.
- R6: Once `acc_o` is 1023 (all ones), further enabled ticks leave it at 1023.
- R7: A high `clr_i` sampled on an edge sets `acc_o` to 0 and restarts the divider phase from that edge. It does not touch the synchroniser.
- R8: `bar_o` always equals `acc_o[9:5]`, with bit 0 of `bar_o` being the least significant segment.
- R9: With the enable held high from just after a clear, `acc_o` reads 1022 after 1023*128-1 edges and 1023 after 1023*128 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 Hz reference clock from the rectified mains |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of divider and accumulator |
| cmp_i | input | 1 | Asynchronous comparator output (load above triangle) |
| tick_o | output | 1 | Count-tick pulse, divide-by-128 |
| pace_o | output | 1 | Triangle pacing pulse, divide-by-1024 |
| acc_o | output | 10 | Accumulated energy count |
| bar_o | output | 5 | Bar indicator segments (top accumulator bits) |

## Verification
The bench targets the following corner cases, and what a wrong design would show in each:

- **Synchroniser latency.** The comparator is raised one cycle before, and then exactly at, the last point where it can still qualify a tick. A design with one flop too many or too few would count the late case or miss the early one.
- **Saturation.** The full-scale run checks the 1022 to 1023 transition and the hold that follows. A wrapping counter would drop the count and the bar to zero.
- **Divider phase after clear.** Random clears are applied mid-phase. A divider that ignored the clear would misplace the next tick and pacing pulse.
- **Tap coincidence.** The bench checks that each pulse is exactly one cycle wide and that the two pulses line up. An off-by-one tap decode would shift or widen them.

// File: rtl/egi_pkg.sv
package egi_pkg;
  localparam int DIV_W     = 10;
  localparam int TICK_LOG2 = 7;
  localparam int PACE_LOG2 = 10;
  localparam int ACC_W     = 10;
  localparam int BAR_W     = 5;
  localparam int N_TAPS    = 2;

  typedef enum int { TAP_TICK = 0, TAP_PACE = 1 } tap_e;
endpackage

// File: rtl/egi_sync.sv
module egi_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic s1_q, s2_q;
  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
    end
  end

  // cycles since reset, saturating at 2, for the latency check only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assign sync_o = s2_q;

  // R5: two-edge latency from the raw input to the enable
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/egi_divider.sv
module egi_divider #(
  parameter int DIV_W     = egi_pkg::DIV_W,
  parameter int TICK_LOG2 = egi_pkg::TICK_LOG2,
  parameter int PACE_LOG2 = egi_pkg::PACE_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o,
  output logic pace_o
);
  import egi_pkg::*;

  localparam int TAP_LG [N_TAPS] = '{TICK_LOG2, PACE_LOG2};

  logic [DIV_W-1:0] phase_q;
  logic [N_TAPS-1:0] tap_hit;

  function automatic logic low_bits_full(input logic [DIV_W-1:0] ph, input int lg);
    logic [DIV_W-1:0] mask;
    mask = DIV_W'((64'd1 << lg) - 64'd1);
    return (ph & mask) == mask;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign tap_hit[g] = rst_n && low_bits_full(phase_q, TAP_LG[g]);
  end

  assign tick_o = tap_hit[TAP_TICK];
  assign pace_o = tap_hit[TAP_PACE];

  // R2: the count tick is a single-cycle pulse
  p_tick_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !clr_i) |=> !tick_o);
  // R3: pacing pulse is single-cycle and coincides with a tick
  p_pace_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_o && !clr_i) |=> !pace_o);
  p_pace_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pace_o |-> tick_o);
endmodule

// File: rtl/egi_accum.sv
module egi_accum #(
  parameter int ACC_W = egi_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             en_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam logic [ACC_W-1:0] FULL = '1;

  logic [ACC_W-1:0] acc_q;
  logic             step;

  function automatic logic [ACC_W-1:0] bump(input logic [ACC_W-1:0] v);
    return (v == FULL) ? v : v + 1'b1;
  endfunction

  assign step = tick_i && en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step)   acc_q <= bump(acc_q);
  end

  assign acc_o = acc_q;

  // R4: advance by one on a qualified tick below full scale
  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && tick_i && en_i && acc_o != FULL) |=> (acc_o == $past(acc_o) + 1'b1));
  // R4: hold when not qualified
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(tick_i && en_i)) |=> $stable(acc_o));
  // R6: no wrap past full scale
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && acc_o == FULL) |=> (acc_o == FULL));
  // R7: clear empties the accumulator
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0));
endmodule

// File: rtl/energy_integrator.sv
module energy_integrator #(
  parameter int DIV_W     = egi_pkg::DIV_W,
  parameter int TICK_LOG2 = egi_pkg::TICK_LOG2,
  parameter int PACE_LOG2 = egi_pkg::PACE_LOG2,
  parameter int ACC_W     = egi_pkg::ACC_W,
  parameter int BAR_W     = egi_pkg::BAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             cmp_i,
  output logic             tick_o,
  output logic             pace_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [BAR_W-1:0] bar_o
);
  localparam int BAR_LSB = ACC_W - BAR_W;

  logic cnt_en;
  logic tick_w;
  logic pace_w;
  logic [ACC_W-1:0] acc_w;

  egi_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cmp_i),
    .sync_o  (cnt_en)
  );

  egi_divider #(
    .DIV_W     (DIV_W),
    .TICK_LOG2 (TICK_LOG2),
    .PACE_LOG2 (PACE_LOG2)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .tick_o (tick_w),
    .pace_o (pace_w)
  );

  egi_accum #(.ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .tick_i (tick_w),
    .en_i   (cnt_en),
    .acc_o  (acc_w)
  );

  assign tick_o = tick_w;
  assign pace_o = pace_w;
  assign acc_o  = acc_w;
  assign bar_o  = acc_w[ACC_W-1:BAR_LSB];

  // R1: quiet outputs while held in reset
  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (tick_o == 1'b0 && pace_o == 1'b0 && acc_o == '0)
        else $error("reset outputs not quiet");
    end
  end
endmodule

// File: tb/sim_energy_integrator.sv
module sim_energy_integrator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic cmp = 1'b0;
  logic tick, pace;
  logic [9:0] acc;
  logic [4:0] bar;

  always #4 clk = ~clk;

  energy_integrator u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cmp_i(cmp),
    .tick_o(tick), .pace_o(pace), .acc_o(acc), .bar_o(bar)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model written from the requirements
  int m_edges = 0;   // edges since last clear/reset
  int m_cnt = 0;
  bit m_s1 = 0, m_s2 = 0;

  function automatic bit exp_tick(int e);
    return (e % 128) == 127;
  endfunction
  function automatic bit exp_pace(int e);
    return (e % 1024) == 1023;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges <= 0; m_cnt <= 0; m_s1 <= 0; m_s2 <= 0;
    end else begin
      m_s1 <= cmp;
      m_s2 <= m_s1;
      if (clr) begin
        m_edges <= 0; m_cnt <= 0;
      end else begin
        m_edges <= m_edges + 1;
        if (exp_tick(m_edges) && m_s2 && m_cnt < 1023) m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance n cycles, comparing every output with the model at each negedge
  task automatic step(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tick == exp_tick(m_edges), {tag, "/R2 tick"}, int'(tick), int'(exp_tick(m_edges)));
      check(pace == exp_pace(m_edges), {tag, "/R3 pace"}, int'(pace), int'(exp_pace(m_edges)));
      check(acc == m_cnt[9:0], {tag, "/R4 acc"}, int'(acc), m_cnt);
      check(bar == m_cnt[9:5], {tag, "/R8 bar"}, int'(bar), int'(m_cnt[9:5]));
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    step(1, "R7");
    clr = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seg_len;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(acc == 0 && bar == 0, "R1 acc/bar", int'(acc), 0);
    check(tick == 0 && pace == 0, "R1 tick/pace", int'(tick) + int'(pace), 0);
    rst_n = 1'b1;
    step(2, "R1");

    // random comparator duty with occasional clears (R4, R7)
    for (int s = 0; s < 60; s++) begin
      cmp = 1'($urandom % 2);
      seg_len = 1 + int'($urandom % 400);
      if (($urandom % 8) == 0) begin
        do_clear();
        check(acc == 0, "R7 clear empties", int'(acc), 0);
      end
      step(seg_len, "R4");
    end

    // R2 / R3 phase after clear
    cmp = 1'b0;
    do_clear();
    step(127, "R2");
    check(tick == 1 && pace == 0, "R2 tick at 127", int'(tick), 1);
    step(1, "R2");
    check(tick == 0, "R2 single-cycle", int'(tick), 0);
    step(1023 - 128, "R3");
    check(pace == 1 && tick == 1, "R3 pace with tick", int'(pace), 1);
    step(1, "R3");
    check(pace == 0, "R3 single-cycle", int'(pace), 0);

    // R5: latest qualifying comparator edge
    cmp = 1'b0;
    step(3, "R5");
    do_clear();
    step(125, "R5");
    cmp = 1'b1;
    step(5, "R5");
    check(acc == 1, "R5 in time", int'(acc), 1);
    // R5: one cycle too late
    cmp = 1'b0;
    step(3, "R5");
    do_clear();
    step(126, "R5");
    cmp = 1'b1;
    step(4, "R5");
    check(acc == 0, "R5 too late", int'(acc), 0);

    // R9 / R6: full-scale run and saturation
    cmp = 1'b0;
    step(3, "R9");
    do_clear();
    cmp = 1'b1;
    step(1023 * 128 - 1, "R9");
    check(acc == 1022, "R9 one short", int'(acc), 1022);
    step(1, "R9");
    check(acc == 1023, "R9 full scale", int'(acc), 1023);
    check(bar == 5'd31, "R8 bar full", int'(bar), 31);
    step(400, "R6");
    check(acc == 1023, "R6 saturated hold", int'(acc), 1023);

    // R7: clear from full scale
    do_clear();
    check(acc == 0 && bar == 0, "R7 clear from full", int'(acc), 0);
    step(10, "R7");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule